// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block tracks a single reservation on behalf of one local requester, so that software can build lock-free atomic updates from a load-exclusive / store-exclusive pair. A load-exclusive marks the 64-byte aligned region that holds its address as reserved and is passed to memory as a read. Between the load and the store, the requester may run any amount of computation. A later store-exclusive reaches memory only if the reservation is still valid and covers the store address. Every store-exclusive returns a status word: zero for success and nonzero for failure. Software retries the sequence whenever it sees a nonzero status.

Writes to the reserved region clear the reservation. These can be plain stores from the local requester or writes seen on the snoop input from other agents. Every store-exclusive consumes the reservation, whether it passes or fails. A new load-exclusive always replaces the old reservation. The memory write port and the status are combinational from the request and the current reservation. The reservation itself changes at the clock edge.

Top module: `excl_monitor`

## Requirements
- R1: An operation code of 1 on `req_op` is a load-exclusive. In the same cycle it raises `mem_rd_en` with `mem_rd_addr` equal to `req_addr`, and it reserves the region `req_addr[31:6]`.
- R2: A store-exclusive (code 2) succeeds when a valid reservation covers any byte address of its 64-byte region and no snoop write hits that region in the same cycle. On success it drives `mem_wr_en`, `mem_wr_addr` and `mem_wr_data` from the request in that cycle and reports status 0.
- R3: A store-exclusive that does not succeed leaves `mem_wr_en` low and reports status 1. This includes a store to an address outside the reserved region.
- R4: Every store-exclusive clears the reservation, whether it passes or fails. A second store-exclusive with no load-exclusive in between therefore fails.
- R5: A reservation persists across any number of idle cycles (code 0).
- R6: A snoop write whose address falls in the reserved region clears the reservation. If it arrives in the same cycle as a store-exclusive to that region, the store fails.
- R7: A snoop write outside the reserved region leaves the reservation intact.
- R8: A plain store (code 3) is always written to memory in its own cycle and never reports a status. If it falls in the reserved region it clears the reservation; otherwise the reservation is unaffected.
- R9: A load-exclusive replaces any earlier reservation, so a store-exclusive to the old region then fails.
- R10: After reset there is no reservation, so a first store-exclusive fails. No memory strobe or status is active while the requester is idle.
- R11: A load-exclusive that meets a snoop write to its own region in the same cycle leaves no reservation.
- R12: `stx_status_valid` is high exactly in the cycles carrying a store-exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_op | input | 2 | 0 idle, 1 load-exclusive, 2 store-exclusive, 3 plain store |
| req_addr | input | ADDR_W | Byte address of the request |
| req_data | input | DATA_W | Store data |
| snoop_valid | input | 1 | Write by another agent observed this cycle |
| snoop_addr | input | ADDR_W | Address of the observed write |
| mem_rd_en | output | 1 | Read strobe for a load-exclusive |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_wr_en | output | 1 | Write strobe toward memory |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | DATA_W | Write data |
| stx_status_valid | output | 1 | Status word valid this cycle |
| stx_status | output | DATA_W | 0 success, 1 failure |

## Verification
The bench targets region edges. Stores to byte 0 and byte 63 of a reserved region must pass, and byte 64 must fail. A comparator that kept too many or too few address bits would pass the wrong one. It also drives the collisions: a snoop write in the same cycle as a store-exclusive or as a load-exclusive to the same region. A design that let the store win would write memory that another agent had just changed. Back-to-back store-exclusives, and plain stores inside and just outside the region, catch a monitor that keeps its reservation too long or drops it too eagerly. A long deterministic sweep of mixed operations, offsets and snoops is then compared against a reservation model kept in the bench.

// File: rtl/excl_pkg.sv
package excl_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LDX  = 2'd1,
    OP_STX  = 2'd2,
    OP_ST   = 2'd3
  } excl_op_e;

  localparam int unsigned STAT_PASS = 0;
  localparam int unsigned STAT_FAIL = 1;
endpackage

// File: rtl/excl_rst_sync.sv
// Asynchronous assert, synchronous release.
module excl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/excl_tag_cmp.sv
// Compares the region part of an address with a stored region tag.
module excl_tag_cmp #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LSB    = 6,
  localparam int unsigned TAG_W = ADDR_W - LSB
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  tag,
  output logic              hit
);
  assign hit = en && (addr[ADDR_W-1:LSB] == tag);
endmodule

// File: rtl/excl_resv_state.sv
// Holds the single reservation: valid bit plus region tag.
module excl_resv_state #(
  parameter int unsigned TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             set_block,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             kill,
  output logic             resv_valid,
  output logic [TAG_W-1:0] resv_tag
);
  logic             valid_n;
  logic             tag_en;
  logic [TAG_W-1:0] tag_n;

  always_comb begin
    valid_n = resv_valid;
    tag_en  = 1'b0;
    tag_n   = resv_tag;
    if (set_en) begin
      valid_n = !set_block;
      tag_en  = 1'b1;
      tag_n   = set_tag;
    end else if (kill) begin
      valid_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      resv_tag   <= '0;
    end else begin
      resv_valid <= valid_n;
      if (tag_en) resv_tag <= tag_n;
    end
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned REGION_LSB = 6,
  localparam int unsigned TAG_W     = ADDR_W - REGION_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              stx_status_valid,
  output logic [DATA_W-1:0] stx_status
);
  localparam int unsigned NCMP = 3;  // req vs resv, snoop vs resv, snoop vs req

  excl_op_e         op;
  logic             rst_q_n;
  logic             resv_valid;
  logic [TAG_W-1:0] resv_tag;
  logic             is_ldx, is_stx, is_st;
  logic             stx_pass, kill;

  logic [NCMP-1:0]             cmp_en;
  logic [NCMP-1:0][ADDR_W-1:0] cmp_addr;
  logic [NCMP-1:0][TAG_W-1:0]  cmp_tag;
  logic [NCMP-1:0]             cmp_hit;

  assign op     = excl_op_e'(req_op);
  assign is_ldx = (op == OP_LDX);
  assign is_stx = (op == OP_STX);
  assign is_st  = (op == OP_ST);

  excl_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign cmp_en   = {snoop_valid, snoop_valid, resv_valid};
  assign cmp_addr = {snoop_addr, snoop_addr, req_addr};
  assign cmp_tag  = {req_addr[ADDR_W-1:REGION_LSB], resv_tag, resv_tag};

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    excl_tag_cmp #(.ADDR_W(ADDR_W), .LSB(REGION_LSB)) u_cmp (
      .en   (cmp_en[g] && (g != 0 || resv_valid)),
      .addr (cmp_addr[g]),
      .tag  (cmp_tag[g]),
      .hit  (cmp_hit[g])
    );
  end

  // cmp_hit[0]: request in reserved region; [1]: snoop in reserved region;
  // [2]: snoop in the request's own region.
  assign stx_pass = is_stx && cmp_hit[0] && !cmp_hit[1];
  assign kill     = is_stx || (is_st && cmp_hit[0]) || cmp_hit[1];

  excl_resv_state #(.TAG_W(TAG_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .set_en     (is_ldx),
    .set_block  (cmp_hit[2]),
    .set_tag    (req_addr[ADDR_W-1:REGION_LSB]),
    .kill       (kill),
    .resv_valid (resv_valid),
    .resv_tag   (resv_tag)
  );

  assign mem_rd_en        = is_ldx;
  assign mem_rd_addr      = req_addr;
  assign mem_wr_en        = is_st || stx_pass;
  assign mem_wr_addr      = req_addr;
  assign mem_wr_data      = req_data;
  assign stx_status_valid = is_stx;
  assign stx_status       = stx_pass ? DATA_W'(STAT_PASS) : DATA_W'(STAT_FAIL);
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned REGION_LSB = 6
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              snoop_valid,
  input logic [ADDR_W-1:0] snoop_addr,
  input logic              mem_wr_en,
  input logic              stx_status_valid,
  input logic [DATA_W-1:0] stx_status,
  input logic              resv_valid
);
  // R3: a failed store-exclusive never writes
  assert_fail_no_write_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (stx_status_valid && stx_status != '0) |-> !mem_wr_en);

  // R4: back-to-back store-exclusives, the second always fails
  assert_stx_consumes_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(req_op) == 2'd2 && req_op == 2'd2) |-> stx_status != '0);

  // R2: load-exclusive then store-exclusive to same region, no snoops, passes
  assert_pair_pass_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(req_op) == 2'd1 && !$past(snoop_valid) && req_op == 2'd2 && !snoop_valid
     && req_addr[ADDR_W-1:REGION_LSB] == $past(req_addr[ADDR_W-1:REGION_LSB]))
    |-> (mem_wr_en && stx_status == '0));

  // R6: a snoop into the store's region in the same cycle makes it fail
  assert_snoop_kills_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_op == 2'd2 && snoop_valid &&
     snoop_addr[ADDR_W-1:REGION_LSB] == req_addr[ADDR_W-1:REGION_LSB])
    |-> (!mem_wr_en && stx_status != '0));

  // R5: idle cycle with no snoop keeps the reservation unchanged
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_op == 2'd0 && !snoop_valid) |=> $stable(resv_valid));

  // R12: status only on store-exclusive cycles
  assert_status_cycle_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_op != 2'd2) |-> !stx_status_valid);
endmodule

bind excl_monitor excl_monitor_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGION_LSB(REGION_LSB)
) u_chk (
  .clk              (clk),
  .rst_q_n          (rst_q_n),
  .req_op           (req_op),
  .req_addr         (req_addr),
  .snoop_valid      (snoop_valid),
  .snoop_addr       (snoop_addr),
  .mem_wr_en        (mem_wr_en),
  .stx_status_valid (stx_status_valid),
  .stx_status       (stx_status),
  .resv_valid       (resv_valid)
);

// File: tb/sim_excl_monitor.sv
`timescale 1ns/1ps
module sim_excl_monitor;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          mem_rd_en, mem_wr_en, stx_status_valid;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [DW-1:0] mem_wr_data, stx_status;

  int n_chk = 0;
  int n_fail = 0;
  logic          m_valid = 1'b0;
  logic [25:0]   m_tag = '0;

  always #10 clk = ~clk;

  excl_monitor u0 (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .stx_status_valid(stx_status_valid), .stx_status(stx_status)
  );

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // One request cycle: drive at negedge, check combinational outputs,
  // then advance the bench's reservation model for the coming edge.
  task automatic step(input logic [1:0] op, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic sv,
                      input logic [AW-1:0] sa, input string rq);
    logic pass, wr;
    @(negedge clk);
    req_op = op; req_addr = a; req_data = d; snoop_valid = sv; snoop_addr = sa;
    #2;
    pass = (op == 2'd2) && m_valid && (a[31:6] == m_tag) && !(sv && sa[31:6] == m_tag);
    wr   = (op == 2'd3) || pass;
    chk(rq, "mem_wr_en", 64'(mem_wr_en), 64'(wr));
    chk(rq, "mem_rd_en", 64'(mem_rd_en), 64'(op == 2'd1));
    chk(rq, "status_valid", 64'(stx_status_valid), 64'(op == 2'd2));
    if (op == 2'd2) chk(rq, "status", 64'(stx_status), pass ? 64'd0 : 64'd1);
    if (wr) begin
      chk(rq, "wr_addr", 64'(mem_wr_addr), 64'(a));
      chk(rq, "wr_data", 64'(mem_wr_data), 64'(d));
    end
    if (op == 2'd1) chk(rq, "rd_addr", 64'(mem_rd_addr), 64'(a));
    if (op == 2'd1) begin
      m_valid = !(sv && sa[31:6] == a[31:6]);
      m_tag   = a[31:6];
    end else if (op == 2'd2) begin
      m_valid = 1'b0;
    end else begin
      if (op == 2'd3 && m_valid && a[31:6] == m_tag) m_valid = 1'b0;
      if (sv && m_valid && sa[31:6] == m_tag) m_valid = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(2'd0, '0, '0, 1'b0, '0, "R5");
  endtask

  initial begin
    #(20 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R10: reset state
    step(2'd0, 32'h100, 32'h1, 1'b0, '0, "R10");
    step(2'd2, 32'h100, 32'h1, 1'b0, '0, "R10");
    // R1, R2: claim then store, edge bytes of the region
    step(2'd1, 32'h1000, '0, 1'b0, '0, "R1");
    step(2'd2, 32'h103F, 32'hA5, 1'b0, '0, "R2");
    step(2'd1, 32'h103F, '0, 1'b0, '0, "R1");
    step(2'd2, 32'h1000, 32'h5A, 1'b0, '0, "R2");
    // R3: store just past the region fails
    step(2'd1, 32'h1000, '0, 1'b0, '0, "R1");
    step(2'd2, 32'h1040, 32'h77, 1'b0, '0, "R3");
    // R4: double store-exclusive
    step(2'd1, 32'h2000, '0, 1'b0, '0, "R1");
    step(2'd2, 32'h2004, 32'h1, 1'b0, '0, "R4");
    step(2'd2, 32'h2004, 32'h2, 1'b0, '0, "R4");
    // R5: long hold
    step(2'd1, 32'h3000, '0, 1'b0, '0, "R1");
    idle(300);
    step(2'd2, 32'h3008, 32'h9, 1'b0, '0, "R5");
    // R6: snoop clears; snoop colliding with store
    step(2'd1, 32'h4000, '0, 1'b0, '0, "R1");
    step(2'd0, '0, '0, 1'b1, 32'h403C, "R6");
    step(2'd2, 32'h4000, 32'h3, 1'b0, '0, "R6");
    step(2'd1, 32'h4000, '0, 1'b0, '0, "R1");
    step(2'd2, 32'h4010, 32'h3, 1'b1, 32'h4020, "R6");
    // R7: snoop outside region
    step(2'd1, 32'h5000, '0, 1'b0, '0, "R1");
    step(2'd0, '0, '0, 1'b1, 32'h5040, "R7");
    step(2'd0, '0, '0, 1'b1, 32'h4FFF, "R7");
    step(2'd2, 32'h5000, 32'h4, 1'b0, '0, "R7");
    // R8: plain stores outside then inside
    step(2'd1, 32'h6000, '0, 1'b0, '0, "R1");
    step(2'd3, 32'h6040, 32'hB, 1'b0, '0, "R8");
    step(2'd2, 32'h6000, 32'hC, 1'b0, '0, "R8");
    step(2'd1, 32'h6000, '0, 1'b0, '0, "R1");
    step(2'd3, 32'h6020, 32'hD, 1'b0, '0, "R8");
    step(2'd2, 32'h6000, 32'hE, 1'b0, '0, "R8");
    // R9: replacement
    step(2'd1, 32'h7000, '0, 1'b0, '0, "R1");
    step(2'd1, 32'h8000, '0, 1'b0, '0, "R9");
    step(2'd2, 32'h7000, 32'hF, 1'b0, '0, "R9");
    step(2'd1, 32'h7000, '0, 1'b0, '0, "R1");
    step(2'd1, 32'h8000, '0, 1'b0, '0, "R9");
    step(2'd2, 32'h8030, 32'hF, 1'b0, '0, "R9");
    // R11: claim colliding with snoop
    step(2'd1, 32'h9000, '0, 1'b1, 32'h9008, "R11");
    step(2'd2, 32'h9000, 32'h1, 1'b0, '0, "R11");
    // R12 and sweep of mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int x;
      logic [AW-1:0] base, sbase;
      x = i * 7 + (i >> 3) + (i >> 6);
      base  = (x % 3 == 0) ? 32'h1000 : ((x % 3 == 1) ? 32'h1040 : 32'h2000);
      sbase = ((x >> 2) % 3 == 0) ? 32'h1000 : (((x >> 2) % 3 == 1) ? 32'h1040 : 32'h3000);
      step(2'(x >> 1), base + 32'((x * 13) % 64), 32'(i), (x % 5 == 0),
           sbase + 32'((x * 5) % 64), "R12");
    end
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule